// File: doc/BRIEF.md
# Serial Receiver with Line-Status Flags

This block turns an asynchronous serial line into characters. A sample enable runs at sixteen times the bit rate. On each enabled cycle the receiver looks at the line. It hunts for a start bit and confirms it in the middle of that bit. It then takes each data bit at its centre, least significant bit first. A character holds five to eight data bits, set by the word-length input. An optional parity bit follows, then one or two stop bits.

Finished characters go into a single holding register, which the host empties with a read strobe. The host sees five flags: data ready, overrun, parity error, framing error and break. The four error flags stay set until a separate status-read strobe clears them.

Parity can be checked in four ways:
- odd
- even
- a parity bit that must always be 0
- a parity bit that must always be 1

A character that arrives before the previous one was read overwrites it. A line held low for a whole character, stop bits included, is reported as a break. After a break the receiver waits for the line to go high before it hunts again.

Top module: `uart_rx_status`

## Requirements
- R1: After a synchronous reset, `rx_data` is 0 and all five flags (`data_ready`, `overrun`, `parity_err`, `framing_err`, `break_det`) are 0.
- R2: Data bits are assembled least significant bit first. `word_len` sets the character length: 00 is 5, 01 is 6, 10 is 7 and 11 is 8 bits. Bits of `rx_data` above the character length read 0.
- R3: A start bit counts only if the line is still low 8 sample enables after the falling edge was seen. A shorter low pulse produces no character.
- R4: With `parity_en` set, `parity_mode` 00 (odd) expects the count of ones in data plus parity to be odd. Mode 01 (even) expects that count to be even. A mismatch sets `parity_err`. For example, odd data 11010010 takes parity 1, even data 10000101 takes 1 and even data 00001111 takes 0.
- R5: `parity_mode` 10 expects a parity bit of 0 and mode 11 expects a parity bit of 1, whatever the data. A different bit sets `parity_err`.
- R6: A stop bit sampled low sets `framing_err`, and the character is still loaded. With `stop_two` set, both stop bits are checked.
- R7: `data_ready` rises when a character is loaded into the holding register. It falls after a `data_rd` pulse when no new character completes in that same cycle.
- R8: When a character completes while `data_ready` is set and no read is under way, the new character replaces the old one and `overrun` is set.
- R9: `overrun`, `parity_err`, `framing_err` and `break_det` stay set until a `status_rd` pulse clears them. `data_rd` does not clear them.
- R10: If data, parity and every stop bit are all sampled low, `break_det` is set and no character is loaded. The receiver then ignores the line until it is sampled high, and after that it receives normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Sample enable at 16 times the bit rate |
| rx_in | input | 1 | Serial input, already synchronised, idle high |
| word_len | input | 2 | Character length code (00 = 5 bits ... 11 = 8 bits) |
| parity_en | input | 1 | A parity bit follows the data |
| parity_mode | input | 2 | 00 odd, 01 even, 10 always 0, 11 always 1 |
| stop_two | input | 1 | Two stop bits expected |
| data_rd | input | 1 | Host read of the holding register |
| status_rd | input | 1 | Host read of the status, clears the error flags |
| rx_data | output | 8 | Holding register |
| data_ready | output | 1 | Holding register holds an unread character |
| overrun | output | 1 | Sticky: an unread character was overwritten |
| parity_err | output | 1 | Sticky: a parity mismatch was seen |
| framing_err | output | 1 | Sticky: a stop bit was sampled low |
| break_det | output | 1 | Sticky: a break condition was seen |

## Verification
A bit counter or sample phase that slips shows up on the very next frame: the character is shifted or misaligned, or a false framing or parity flag appears, one bit time after the stop bit. A start-detection fault shows either as a character from a short glitch or as a lost frame. Either is visible right after the frame. Flag-state faults show at the next status read or data read, because the sticky bits fail to hold or fail to clear. After a break, a wrong wait state produces a spurious character or leaves the next real frame unreceived.

// File: rtl/uart_rx_pkg.sv
// Package: shared types of the serial receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_rx_pkg;

    // Receiver frame states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKW
    } rx_state_e;

    // Parity check modes, as coded on parity_mode
    typedef enum logic [1:0] {
        PM_ODD   = 2'b00,
        PM_EVEN  = 2'b01,
        PM_SPACE = 2'b10,
        PM_MARK  = 2'b11
    } par_mode_e;

endpackage

// File: rtl/rx_parity_calc.sv
// Module: computes the parity bit that the configured mode expects.
// Assumes: bits of char_in above the character length are 0.
module rx_parity_calc #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] char_in,
    input  logic [1:0]        mode,
    output logic              exp_bit
);
    import uart_rx_pkg::*;

    // Select the expected parity bit from the mode and the data ones count
    always_comb begin
        unique case (par_mode_e'(mode))
            PM_ODD:   exp_bit = ~(^char_in);
            PM_EVEN:  exp_bit = ^char_in;
            PM_SPACE: exp_bit = 1'b0;
            default:  exp_bit = 1'b1;
        endcase
    end
endmodule

// File: rtl/rx_frame_fsm.sv
// Module: hunts for the start bit, samples data, parity and stop bits at
// bit centres, and pulses done or brk one cycle after the last stop bit.
// Assumes: rx_in is synchronised; the configuration is stable during a frame.
module rx_frame_fsm #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rx_in,
    input  logic [1:0]        word_len,
    input  logic              parity_en,
    input  logic              stop_two,
    output logic [DATA_W-1:0] char_q,
    output logic              par_q,
    output logic              done,
    output logic              brk,
    output logic              frm_err
);
    import uart_rx_pkg::*;

    localparam int CNT_W    = $clog2(OVS);
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int MIN_BITS = DATA_W - 3;
    localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(OVS - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] tick;
    logic [BIT_W-1:0] bitn;
    logic [BIT_W-1:0] last_idx;
    logic             stop_n;
    logic             stop_bad;
    logic             all_zero;
    logic             at_centre;

    assign last_idx  = BIT_W'(MIN_BITS - 1) + BIT_W'(word_len);
    assign at_centre = sample_en && (tick == FULL);

    // Frame sequencing, bit capture and completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tick     <= '0;
            bitn     <= '0;
            stop_n   <= 1'b0;
            stop_bad <= 1'b0;
            all_zero <= 1'b1;
            char_q   <= '0;
            par_q    <= 1'b0;
            done     <= 1'b0;
            brk      <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            done    <= 1'b0;
            brk     <= 1'b0;
            frm_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (sample_en && !rx_in) begin
                        state <= ST_START;
                        tick  <= '0;
                    end
                end
                ST_START: begin
                    if (sample_en) begin
                        if (tick == HALF) begin
                            tick <= '0;
                            if (!rx_in) begin
                                state    <= ST_DATA;
                                bitn     <= '0;
                                stop_n   <= 1'b0;
                                stop_bad <= 1'b0;
                                all_zero <= 1'b1;
                                char_q   <= '0;
                                par_q    <= 1'b0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            tick <= tick + 1'b1;
                        end
                    end
                end
                ST_DATA, ST_PAR, ST_STOP: begin
                    if (sample_en) tick <= tick + 1'b1;
                    if (at_centre) begin
                        tick     <= '0;
                        all_zero <= all_zero & ~rx_in;
                        if (state == ST_DATA) begin
                            char_q[bitn] <= rx_in;
                            bitn         <= bitn + 1'b1;
                            if (bitn == last_idx)
                                state <= parity_en ? ST_PAR : ST_STOP;
                        end else if (state == ST_PAR) begin
                            par_q <= rx_in;
                            state <= ST_STOP;
                        end else if (stop_two && !stop_n) begin
                            stop_n   <= 1'b1;
                            stop_bad <= ~rx_in;
                        end else if (all_zero && !rx_in) begin
                            brk   <= 1'b1;
                            state <= ST_BRKW;
                        end else begin
                            done    <= 1'b1;
                            frm_err <= stop_bad | ~rx_in;
                            state   <= ST_IDLE;
                        end
                    end
                end
                ST_BRKW: begin
                    if (sample_en && rx_in) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_status_regs.sv
// Module: holding register, data-ready and the sticky error flags.
// Assumes: done and brk are single-cycle pulses that never coincide.
module rx_status_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              brk,
    input  logic              frm_err,
    input  logic              par_bad,
    input  logic [DATA_W-1:0] char_in,
    input  logic              data_rd,
    input  logic              status_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun,
    output logic              parity_err,
    output logic              framing_err,
    output logic              break_det
);
    // Load the character and track unread data; a load wins over a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
        end else if (done) begin
            rx_data    <= char_in;
            data_ready <= 1'b1;
        end else if (data_rd) begin
            data_ready <= 1'b0;
        end
    end

    // Sticky error flags: a new event wins over a status-read clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun     <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            break_det   <= 1'b0;
        end else begin
            overrun     <= (done && data_ready && !data_rd) || (overrun && !status_rd);
            parity_err  <= (done && par_bad) || (parity_err && !status_rd);
            framing_err <= (done && frm_err) || (framing_err && !status_rd);
            break_det   <= brk || (break_det && !status_rd);
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
// Module: top of the serial receiver; joins the frame sequencer, the parity
// check and the status registers.
// Assumes: rx_in is synchronised to clk; sample_en pulses 16 times per bit.
module uart_rx_status #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rx_in,
    input  logic [1:0]        word_len,
    input  logic              parity_en,
    input  logic [1:0]        parity_mode,
    input  logic              stop_two,
    input  logic              data_rd,
    input  logic              status_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun,
    output logic              parity_err,
    output logic              framing_err,
    output logic              break_det
);
    logic [DATA_W-1:0] char_q;
    logic              par_q;
    logic              done;
    logic              brk;
    logic              frm_err;
    logic              exp_bit;
    logic              par_bad;

    rx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .rx_in     (rx_in),
        .word_len  (word_len),
        .parity_en (parity_en),
        .stop_two  (stop_two),
        .char_q    (char_q),
        .par_q     (par_q),
        .done      (done),
        .brk       (brk),
        .frm_err   (frm_err)
    );

    rx_parity_calc #(.DATA_W(DATA_W)) u_par (
        .char_in (char_q),
        .mode    (parity_mode),
        .exp_bit (exp_bit)
    );

    assign par_bad = parity_en && (par_q != exp_bit);

    rx_status_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .brk         (brk),
        .frm_err     (frm_err),
        .par_bad     (par_bad),
        .char_in     (char_q),
        .data_rd     (data_rd),
        .status_rd   (status_rd),
        .rx_data     (rx_data),
        .data_ready  (data_ready),
        .overrun     (overrun),
        .parity_err  (parity_err),
        .framing_err (framing_err),
        .break_det   (break_det)
    );
endmodule

// File: rtl/uart_rx_status_chk.sv
// Module: protocol checker for the receiver top, attached by bind.
// Assumes: observes the internal completion pulses done and brk of the top.
module uart_rx_status_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic brk,
    input logic data_rd,
    input logic status_rd,
    input logic data_ready,
    input logic overrun,
    input logic parity_err,
    input logic framing_err,
    input logic break_det
);
    a_r7_ready_after_char: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> data_ready);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !done) |=> !data_ready);
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done && data_ready && !data_rd) |=> overrun);
    a_r9_sticky_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !status_rd) |=> overrun);
    a_r9_sticky_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err && !status_rd) |=> parity_err);
    a_r9_sticky_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (framing_err && !status_rd) |=> framing_err);
    a_r10_break_flag: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> break_det);
    a_r10_break_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !data_rd && !data_ready) |=> !data_ready);
    a_r10_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
        !(brk && done));
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .brk         (brk),
    .data_rd     (data_rd),
    .status_rd   (status_rd),
    .data_ready  (data_ready),
    .overrun     (overrun),
    .parity_err  (parity_err),
    .framing_err (framing_err),
    .break_det   (break_det)
);

// File: tb/test_uart_rx_status.sv
// Bench: directed scenarios, one task each; sample_en held high so one bit
// lasts 16 clocks. Inputs change on the falling edge, outputs sampled there.
module test_uart_rx_status;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b1;
    logic       rx_in = 1'b1;
    logic [1:0] word_len = 2'b11;
    logic       parity_en = 1'b0;
    logic [1:0] parity_mode = 2'b00;
    logic       stop_two = 1'b0;
    logic       data_rd = 1'b0;
    logic       status_rd = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, overrun, parity_err, framing_err, break_det;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_status i_uart_rx_status (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_in(rx_in),
        .word_len(word_len), .parity_en(parity_en), .parity_mode(parity_mode),
        .stop_two(stop_two), .data_rd(data_rd), .status_rd(status_rd),
        .rx_data(rx_data), .data_ready(data_ready), .overrun(overrun),
        .parity_err(parity_err), .framing_err(framing_err), .break_det(break_det)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold_bit(input logic b);
        rx_in = b;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    // Serial frame: start, nb data bits LSB first, optional parity, stops
    task automatic send(input logic [7:0] d, input int nb, input logic pb,
                        input logic s1, input logic s2);
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) hold_bit(d[i]);
        if (parity_en) hold_bit(pb);
        hold_bit(s1);
        if (stop_two) hold_bit(s2);
        hold_bit(1'b1);
        hold_bit(1'b1);
    endtask

    task automatic pulse_rd();
        data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_st();
        status_rd = 1'b1; @(negedge clk); status_rd = 1'b0; @(negedge clk);
    endtask

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] m);
        case (m)
            2'b00: return ~(^d);
            2'b01: return ^d;
            2'b10: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic t_reset();
        chk("R1 rx_data", rx_data, 0);
        chk("R1 flags", {data_ready, overrun, parity_err, framing_err, break_det}, 0);
    endtask

    task automatic t_assembly();
        word_len = 2'b11;
        send(8'hA5, 8, 1'b0, 1'b1, 1'b1);
        chk("R2 8-bit data", rx_data, 8'hA5);
        chk("R7 ready set", data_ready, 1);
        pulse_rd();
        chk("R7 ready cleared", data_ready, 0);
        word_len = 2'b00;
        send(8'hF5, 5, 1'b0, 1'b1, 1'b1);
        chk("R2 5-bit data", rx_data, 8'h15);
        pulse_rd();
        word_len = 2'b10;
        send(8'h4E, 7, 1'b0, 1'b1, 1'b1);
        chk("R2 7-bit data", rx_data, 8'h4E);
        pulse_rd();
        word_len = 2'b11;
    endtask

    task automatic t_glitch();
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (3*BIT_CYC) @(negedge clk);
        chk("R3 glitch rejected", data_ready, 0);
    endtask

    task automatic t_parity_oe();
        parity_en = 1'b1;
        parity_mode = 2'b00;
        chk("R4 odd ref 11010010", exp_par(8'b11010010, 2'b00), 1);
        send(8'b11010010, 8, 1'b1, 1'b1, 1'b1);
        chk("R4 odd good", parity_err, 0);
        send(8'b11010010, 8, 1'b0, 1'b1, 1'b1);
        chk("R4 odd bad", parity_err, 1);
        pulse_rd(); pulse_st();
        parity_mode = 2'b01;
        send(8'b10000101, 8, 1'b1, 1'b1, 1'b1);
        chk("R4 even good 10000101", parity_err, 0);
        send(8'b00001111, 8, 1'b0, 1'b1, 1'b1);
        chk("R4 even good 00001111", parity_err, 0);
        send(8'b00001111, 8, 1'b1, 1'b1, 1'b1);
        chk("R4 even bad", parity_err, 1);
        pulse_rd(); pulse_st();
    endtask

    task automatic t_parity_forced();
        parity_mode = 2'b11;
        send(8'h0F, 8, 1'b1, 1'b1, 1'b1);
        chk("R5 mark good", parity_err, 0);
        send(8'h0E, 8, 1'b0, 1'b1, 1'b1);
        chk("R5 mark bad", parity_err, 1);
        pulse_rd(); pulse_st();
        parity_mode = 2'b10;
        send(8'h07, 8, 1'b0, 1'b1, 1'b1);
        chk("R5 space good", parity_err, 0);
        send(8'h07, 8, 1'b1, 1'b1, 1'b1);
        chk("R5 space bad", parity_err, 1);
        pulse_rd();
        pulse_rd();
        chk("R9 parity kept after data read", parity_err, 1);
        pulse_st();
        chk("R9 parity cleared by status read", parity_err, 0);
        parity_en = 1'b0;
    endtask

    task automatic t_framing();
        send(8'h55, 8, 1'b0, 1'b0, 1'b1);
        chk("R6 framing set", framing_err, 1);
        chk("R6 char loaded", rx_data, 8'h55);
        pulse_rd();
        chk("R9 framing sticky", framing_err, 1);
        pulse_st();
        chk("R9 framing cleared", framing_err, 0);
        stop_two = 1'b1;
        send(8'h3C, 8, 1'b0, 1'b1, 1'b1);
        chk("R6 two stops good", framing_err, 0);
        send(8'h3C, 8, 1'b0, 1'b1, 1'b0);
        chk("R6 second stop low", framing_err, 1);
        pulse_rd(); pulse_st();
        stop_two = 1'b0;
    endtask

    task automatic t_overrun();
        send(8'h11, 8, 1'b0, 1'b1, 1'b1);
        send(8'h22, 8, 1'b0, 1'b1, 1'b1);
        chk("R8 overwritten", rx_data, 8'h22);
        chk("R8 overrun set", overrun, 1);
        pulse_rd();
        chk("R9 overrun sticky", overrun, 1);
        pulse_st();
        chk("R9 overrun cleared", overrun, 0);
    endtask

    task automatic t_break();
        rx_in = 1'b0;
        repeat (14*BIT_CYC) @(negedge clk);
        chk("R10 break set", break_det, 1);
        chk("R10 no char", data_ready, 0);
        chk("R10 no framing", framing_err, 0);
        rx_in = 1'b1;
        repeat (2*BIT_CYC) @(negedge clk);
        send(8'h9B, 8, 1'b0, 1'b1, 1'b1);
        chk("R10 receives after break", rx_data, 8'h9B);
        chk("R10 ready after break", data_ready, 1);
        pulse_st();
        chk("R9 break cleared", break_det, 0);
        pulse_rd();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_assembly();
        t_glitch();
        t_parity_oe();
        t_parity_forced();
        t_framing();
        t_overrun();
        t_break();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule